// File: doc/BRIEF.md
# Trap Return Unit

This block carries out the two trap-return operations of a processor core: the return from a machine-level trap and the return from a supervisor-level trap. A one-cycle request names the kind of return and presents the current privilege, the current virtualization state, the machine status word, the hypervisor status word and both saved exception PCs. The block checks that the return is permitted and that the target address is aligned. It then computes the updated status words, the privilege and virtualization the core resumes in, and the address to jump to.

All results are registered. They appear in the cycle after the request, marked by a one-cycle done pulse. Exception flags are raised instead of any state change when a check fails. The exchange of the banked hypervisor register set is not done here. It is requested through a single-cycle swap pulse that the surrounding register file acts on.

Privilege encoding is user = 2'b00, supervisor = 2'b01, machine = 2'b11. Status bit positions are fixed in the package. Machine status: supervisor interrupt enable bit 1, machine interrupt enable bit 3, supervisor previous enable bit 5, machine previous enable bit 7, supervisor previous privilege bit 8, machine previous privilege bits 12:11, trap-supervisor-return bit 22, machine previous virtualization bit 39. Hypervisor status: previous virtualization bit 7, second-level previous privilege bit 8, second-level previous virtualization bit 9.

Top module: `trap_ret_unit`

## Requirements
- R1: A machine return (ret_is_mret = 1) is illegal unless cur_priv is 2'b11. A supervisor return is illegal when cur_priv is 2'b00. An illegal return raises exc_illegal.
- R2: When the privilege check passes, c_ext_en is 0 and bits 1:0 of the selected return PC are not 00, exc_misaligned is raised and exc_illegal stays low.
- R3: A supervisor return that passes R1 and R2 while status bit 22 is set raises exc_illegal.
- R4: When either exception flag is raised, status_out equals status_in, hstatus_out equals hstatus_in, new_priv equals cur_priv, new_virt equals cur_virt and bank_swap stays 0.
- R5: A successful machine return copies status bit 7 into bit 3, sets bit 7, clears bits 12:11 and clears bit 39. All other status bits are unchanged and hstatus_out equals hstatus_in.
- R6: A successful machine return sets new_priv to the old bits 12:11. With h_ext_en = 1, new_virt takes the old bit 39 and bank_swap pulses when that bit was 1. With h_ext_en = 0, new_virt keeps cur_virt and no swap occurs.
- R7: A successful supervisor return with h_ext_en = 0 or cur_virt = 1 copies status bit 5 into bit 1, sets bit 5 and clears bit 8. It sets new_priv to {1'b0, old bit 8}, keeps cur_virt and leaves hstatus unchanged.
- R8: A successful supervisor return with h_ext_en = 1 and cur_virt = 0 updates bits 1 and 5 as in R7 and loads status bit 8 from hstatus bit 8. It loads hstatus bit 7 from hstatus bit 9 and clears hstatus bits 8 and 9. new_priv is {1'b0, old status bit 8} and new_virt is the old hstatus bit 7. bank_swap pulses when that old bit was 1.
- R9: Results appear one cycle after ret_valid, with ret_done high for that cycle only. The exception flags and bank_swap are 0 in every cycle without done. Other outputs hold their last value. Synchronous active-low reset gives done 0, flags 0, new_priv 2'b11, new_virt 0, swap 0 and zero status, hstatus and ret_pc.
- R10: ret_pc is mepc_in for a machine return and sepc_in for a supervisor return, whether or not an exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | Return request, one cycle |
| ret_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization state |
| c_ext_en | input | 1 | Compressed instructions enabled |
| h_ext_en | input | 1 | Hypervisor support enabled |
| status_in | input | 64 | Machine status word |
| hstatus_in | input | 64 | Hypervisor status word |
| mepc_in | input | 64 | Saved machine exception PC |
| sepc_in | input | 64 | Saved supervisor exception PC |
| ret_done | output | 1 | Result valid pulse |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_misaligned | output | 1 | Misaligned-target exception |
| new_priv | output | 2 | Privilege after the return |
| new_virt | output | 1 | Virtualization after the return |
| ret_pc | output | 64 | Return target address |
| status_out | output | 64 | Updated machine status word |
| hstatus_out | output | 64 | Updated hypervisor status word |
| bank_swap | output | 1 | Request to swap banked hypervisor registers |

## Verification
The assertions run on every cycle. They cover:
- the illegal-privilege and misalignment flags against the previous cycle's request;
- the freezing of all state when a flag is up;
- the machine-return status fields;
- the rule that a swap pulse only comes with a successful return into a virtualized mode.

The bench's scenarios are the only place where the following are shown:
- the two supervisor paths and the second-level field shifts;
- the order of the misalignment and trap-supervisor-return checks;
- the holding of outputs between requests;
- the reset values.

// File: rtl/trap_ret_pkg.sv
// Shared definitions for the trap return unit.
// Assumes a 64-bit status word layout with the fixed bit positions below.
package trap_ret_pkg;
    parameter int XLEN = 64;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    // machine status word fields
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_TSR    = 22;
    localparam int ST_MPV    = 39;

    // hypervisor status word fields
    localparam int HS_SPV  = 7;
    localparam int HS_SP2P = 8;
    localparam int HS_SP2V = 9;

    typedef struct packed {
        logic illegal;
        logic misaligned;
    } exc_t;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] hstatus;
        logic [1:0]      priv;
        logic            virt;
        logic            swap;
    } ret_state_t;
endpackage

// File: rtl/trap_ret_check.sv
// Legality checks for a trap return.
// Order: privilege first, then target alignment, then the trap-supervisor-return bit.
// Assumes pc_low holds bits 1:0 of the already selected return PC.
module trap_ret_check
    import trap_ret_pkg::*;
(
    input  logic       is_mret,
    input  logic [1:0] cur_priv,
    input  logic [1:0] pc_low,
    input  logic       c_ext_en,
    input  logic       tsr,
    output exc_t       exc
);
    logic priv_ok;
    logic misal;

    // privilege gate for each return kind
    always_comb begin
        if (is_mret) priv_ok = (cur_priv == PRIV_M);
        else         priv_ok = (cur_priv != PRIV_U);
    end

    // misalignment only matters once the privilege check has passed
    always_comb misal = priv_ok && !c_ext_en && (pc_low != 2'b00);

    // combine into the exception record with the fixed priority
    always_comb begin
        exc.misaligned = misal;
        exc.illegal    = !priv_ok || (!misal && !is_mret && tsr);
    end
endmodule

// File: rtl/trap_ret_mstate.sv
// Next-state computation for a machine-level return.
// Assumes the caller discards the result when an exception is raised.
module trap_ret_mstate
    import trap_ret_pkg::*;
(
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] hstatus_in,
    input  logic            cur_virt,
    input  logic            h_ext_en,
    output ret_state_t      nxt
);
    // rewrite the machine stack fields and pick the resume mode
    always_comb begin
        nxt.status                   = status_in;
        nxt.hstatus                  = hstatus_in;
        nxt.status[ST_MIE]           = status_in[ST_MPIE];
        nxt.status[ST_MPIE]          = 1'b1;
        nxt.status[ST_MPP_LO +: 2]   = PRIV_U;
        nxt.status[ST_MPV]           = 1'b0;
        nxt.priv                     = status_in[ST_MPP_LO +: 2];
        if (h_ext_en) begin
            nxt.virt = status_in[ST_MPV];
            nxt.swap = status_in[ST_MPV];
        end else begin
            nxt.virt = cur_virt;
            nxt.swap = 1'b0;
        end
    end
endmodule

// File: rtl/trap_ret_sstate.sv
// Next-state computation for a supervisor-level return.
// Has two variants: the plain one and the hypervisor one, which is taken when
// hypervisor support is on and the hart is not virtualized.
// Assumes the caller discards the result when an exception is raised.
module trap_ret_sstate
    import trap_ret_pkg::*;
(
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] hstatus_in,
    input  logic            cur_virt,
    input  logic            h_ext_en,
    output ret_state_t      nxt
);
    logic hyp_path;

    // choose the hypervisor variant
    always_comb hyp_path = h_ext_en && !cur_virt;

    // rewrite the supervisor stack fields, shifting the second level on the hypervisor path
    always_comb begin
        nxt.status           = status_in;
        nxt.hstatus          = hstatus_in;
        nxt.status[ST_SIE]   = status_in[ST_SPIE];
        nxt.status[ST_SPIE]  = 1'b1;
        nxt.priv             = {1'b0, status_in[ST_SPP]};
        if (hyp_path) begin
            nxt.status[ST_SPP]   = hstatus_in[HS_SP2P];
            nxt.hstatus[HS_SPV]  = hstatus_in[HS_SP2V];
            nxt.hstatus[HS_SP2P] = 1'b0;
            nxt.hstatus[HS_SP2V] = 1'b0;
            nxt.virt             = hstatus_in[HS_SPV];
            nxt.swap             = hstatus_in[HS_SPV];
        end else begin
            nxt.status[ST_SPP]   = 1'b0;
            nxt.virt             = cur_virt;
            nxt.swap             = 1'b0;
        end
    end
endmodule

// File: rtl/trap_ret_unit.sv
// Trap return unit: validates a machine or supervisor return and registers the
// resulting status words, privilege, virtualization, target PC and swap request.
// Assumes ret_valid is a single-cycle request and inputs are stable in that cycle.
module trap_ret_unit
    import trap_ret_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    input  logic            ret_is_mret,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic            c_ext_en,
    input  logic            h_ext_en,
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] hstatus_in,
    input  logic [XLEN-1:0] mepc_in,
    input  logic [XLEN-1:0] sepc_in,
    output logic            ret_done,
    output logic            exc_illegal,
    output logic            exc_misaligned,
    output logic [1:0]      new_priv,
    output logic            new_virt,
    output logic [XLEN-1:0] ret_pc,
    output logic [XLEN-1:0] status_out,
    output logic [XLEN-1:0] hstatus_out,
    output logic            bank_swap
);
    logic [XLEN-1:0] sel_pc;
    exc_t            exc;
    ret_state_t      m_nxt, s_nxt, pick;
    logic            any_exc;

    // return target follows the return kind
    always_comb sel_pc = ret_is_mret ? mepc_in : sepc_in;

    trap_ret_check u_check (
        .is_mret  (ret_is_mret),
        .cur_priv (cur_priv),
        .pc_low   (sel_pc[1:0]),
        .c_ext_en (c_ext_en),
        .tsr      (status_in[ST_TSR]),
        .exc      (exc)
    );

    trap_ret_mstate u_mstate (
        .status_in  (status_in),
        .hstatus_in (hstatus_in),
        .cur_virt   (cur_virt),
        .h_ext_en   (h_ext_en),
        .nxt        (m_nxt)
    );

    trap_ret_sstate u_sstate (
        .status_in  (status_in),
        .hstatus_in (hstatus_in),
        .cur_virt   (cur_virt),
        .h_ext_en   (h_ext_en),
        .nxt        (s_nxt)
    );

    // select the update, or freeze everything when a check fails
    always_comb begin
        any_exc = exc.illegal || exc.misaligned;
        if (any_exc) begin
            pick.status  = status_in;
            pick.hstatus = hstatus_in;
            pick.priv    = cur_priv;
            pick.virt    = cur_virt;
            pick.swap    = 1'b0;
        end else if (ret_is_mret) begin
            pick = m_nxt;
        end else begin
            pick = s_nxt;
        end
    end

    // output register: pulses clear each cycle, results hold between requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_done       <= 1'b0;
            exc_illegal    <= 1'b0;
            exc_misaligned <= 1'b0;
            bank_swap      <= 1'b0;
            new_priv       <= PRIV_M;
            new_virt       <= 1'b0;
            ret_pc         <= '0;
            status_out     <= '0;
            hstatus_out    <= '0;
        end else begin
            ret_done       <= ret_valid;
            exc_illegal    <= ret_valid && exc.illegal;
            exc_misaligned <= ret_valid && exc.misaligned;
            bank_swap      <= ret_valid && pick.swap;
            if (ret_valid) begin
                new_priv    <= pick.priv;
                new_virt    <= pick.virt;
                ret_pc      <= sel_pc;
                status_out  <= pick.status;
                hstatus_out <= pick.hstatus;
            end
        end
    end

    // R1
    mret_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_is_mret && cur_priv != PRIV_M) |=> (ret_done && exc_illegal));

    // R1
    sret_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_is_mret && cur_priv == PRIV_U) |=> (ret_done && exc_illegal));

    // R2
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !c_ext_en && sel_pc[1:0] != 2'b00 &&
         (ret_is_mret ? cur_priv == PRIV_M : cur_priv != PRIV_U))
        |=> (exc_misaligned && !exc_illegal));

    // R4
    freeze_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && (exc_illegal || exc_misaligned)) |->
        (status_out == $past(status_in) && hstatus_out == $past(hstatus_in) &&
         new_priv == $past(cur_priv) && new_virt == $past(cur_virt) && !bank_swap));

    // R5
    mret_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && !exc_illegal && !exc_misaligned && $past(ret_is_mret)) |->
        (status_out[ST_MPIE] && status_out[ST_MPP_LO +: 2] == PRIV_U &&
         !status_out[ST_MPV] && status_out[ST_MIE] == $past(status_in[ST_MPIE])));

    // R8
    swap_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_swap |-> (ret_done && !exc_illegal && !exc_misaligned && new_virt));

    // R9
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_done |-> (!exc_illegal && !exc_misaligned && !bank_swap));
endmodule

// File: tb/trap_ret_unit_bench.sv
// Bench for trap_ret_unit: a behavioural reference model updated on every clock
// and compared against all outputs on every falling edge.
module trap_ret_unit_bench;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ret_valid, ret_is_mret, cur_virt, c_ext_en, h_ext_en;
    logic [1:0]    cur_priv;
    logic [W-1:0]  status_in, hstatus_in, mepc_in, sepc_in;
    logic          ret_done, exc_illegal, exc_misaligned, new_virt, bank_swap;
    logic [1:0]    new_priv;
    logic [W-1:0]  ret_pc, status_out, hstatus_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // reference model state
    bit         e_done, e_ill, e_mis, e_virt, e_swap;
    bit [1:0]   e_priv;
    bit [W-1:0] e_pc, e_st, e_hs;

    always #5 clk = ~clk;

    trap_ret_unit u_trap_ret_unit (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_mret(ret_is_mret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .c_ext_en(c_ext_en), .h_ext_en(h_ext_en),
        .status_in(status_in), .hstatus_in(hstatus_in), .mepc_in(mepc_in), .sepc_in(sepc_in),
        .ret_done(ret_done), .exc_illegal(exc_illegal), .exc_misaligned(exc_misaligned),
        .new_priv(new_priv), .new_virt(new_virt), .ret_pc(ret_pc),
        .status_out(status_out), .hstatus_out(hstatus_out), .bank_swap(bank_swap)
    );

    // reference model: written from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            e_done = 0; e_ill = 0; e_mis = 0; e_swap = 0;
            e_priv = 2'd3; e_virt = 0; e_pc = '0; e_st = '0; e_hs = '0;
        end else begin
            e_done = ret_valid; e_ill = 0; e_mis = 0; e_swap = 0;
            if (ret_valid) begin
                bit [W-1:0] pc;
                bit ok;
                pc = ret_is_mret ? mepc_in : sepc_in;          // R10
                e_pc = pc;
                ok = ret_is_mret ? (cur_priv == 2'd3) : (cur_priv != 2'd0);
                if (!ok) e_ill = 1;                            // R1
                else if (!c_ext_en && pc[1:0] != 0) e_mis = 1; // R2
                else if (!ret_is_mret && status_in[22]) e_ill = 1; // R3
                e_st = status_in; e_hs = hstatus_in; e_priv = cur_priv; e_virt = cur_virt;
                if (!(e_ill || e_mis)) begin
                    if (ret_is_mret) begin                     // R5 R6
                        e_priv = status_in[12:11];
                        e_st[3] = status_in[7]; e_st[7] = 1; e_st[12:11] = 0; e_st[39] = 0;
                        if (h_ext_en) begin e_virt = status_in[39]; e_swap = status_in[39]; end
                    end else begin                             // R7 R8
                        e_priv = {1'b0, status_in[8]};
                        e_st[1] = status_in[5]; e_st[5] = 1;
                        if (h_ext_en && !cur_virt) begin
                            e_st[8] = hstatus_in[8];
                            e_hs[7] = hstatus_in[9]; e_hs[8] = 0; e_hs[9] = 0;
                            e_virt = hstatus_in[7]; e_swap = hstatus_in[7];
                        end else begin
                            e_st[8] = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (!finished) begin
            chk("R9 ret_done",        ret_done,        e_done);
            chk("R1 exc_illegal",     exc_illegal,     e_ill);
            chk("R2 exc_misaligned",  exc_misaligned,  e_mis);
            chk("R6 new_priv",        new_priv,        e_priv);
            chk("R8 new_virt",        new_virt,        e_virt);
            chk("R10 ret_pc",         ret_pc,          e_pc);
            chk("R5 status_out",      status_out,      e_st);
            chk("R8 hstatus_out",     hstatus_out,     e_hs);
            chk("R8 bank_swap",       bank_swap,       e_swap);
        end
    end

    task automatic req(input bit m, input bit [1:0] p, input bit v, input bit c, input bit h,
                       input bit [W-1:0] st, input bit [W-1:0] hs,
                       input bit [W-1:0] mpc, input bit [W-1:0] spc);
        @(negedge clk);
        ret_valid = 1; ret_is_mret = m; cur_priv = p; cur_virt = v; c_ext_en = c; h_ext_en = h;
        status_in = st; hstatus_in = hs; mepc_in = mpc; sepc_in = spc;
        @(negedge clk);
        ret_valid = 0;
        status_in = ~st; hstatus_in = ~hs;  // R9: outputs must hold
    endtask

    initial begin
        rst_n = 0; ret_valid = 0; ret_is_mret = 0; cur_priv = 0; cur_virt = 0;
        c_ext_en = 0; h_ext_en = 0; status_in = '0; hstatus_in = '0; mepc_in = '0; sepc_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;                                     // R9 reset values checked above
        // R1: machine return from supervisor, supervisor return from user
        req(1, 2'd1, 0, 1, 0, 64'h80, 0, 64'h1000, 64'h2000);
        req(0, 2'd0, 0, 1, 0, 64'h20, 0, 64'h1000, 64'h2000);
        // R2 before R3: misaligned with trap bit set
        req(0, 2'd1, 0, 0, 0, 64'h400000, 0, 64'h1000, 64'h2002);
        // R3 and R4: trap bit set, aligned
        req(0, 2'd3, 1, 1, 1, 64'h400120, 64'h380, 64'h1000, 64'h2000);
        // R2 does not apply with compressed on
        req(1, 2'd3, 0, 1, 0, 64'h1880, 0, 64'h1002, 64'h0);
        // R5 R6: machine return with virtualization bit, hypervisor on and off
        req(1, 2'd3, 0, 0, 1, 64'h8000000880, 0, 64'h4000, 0);
        req(1, 2'd3, 1, 0, 0, 64'h8000000800, 0, 64'h4000, 0);
        // R7: plain supervisor return, and virtualized hart with hypervisor on
        req(0, 2'd1, 0, 0, 0, 64'h120, 64'h380, 0, 64'h3000);
        req(0, 2'd1, 1, 0, 1, 64'h120, 64'h380, 0, 64'h3000);
        // R8: hypervisor path with old SPV set and clear
        req(0, 2'd3, 0, 0, 1, 64'h20, 64'h380, 0, 64'h3000);
        req(0, 2'd1, 0, 0, 1, 64'h120, 64'h200, 0, 64'h3000);
        // mixed stimulus
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ret_valid   = ($urandom % 3) != 0;
            ret_is_mret = $urandom % 2;
            cur_priv    = ($urandom % 3 == 2) ? 2'd3 : 2'($urandom % 2);
            cur_virt    = $urandom % 2;
            c_ext_en    = $urandom % 2;
            h_ext_en    = $urandom % 2;
            status_in   = {$urandom, $urandom};
            if ($urandom % 4 != 0) status_in[22] = 1'b0;
            hstatus_in  = {$urandom, $urandom};
            mepc_in     = {$urandom, $urandom};
            sepc_in     = {$urandom, $urandom};
        end
        @(negedge clk);
        ret_valid = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule